// File: doc/BRIEF.md
# Single-Bit Test/Set/Clear/Invert Unit

This unit carries out one single-bit operation per issue on an 8-bit or 16-bit operand. The operation is either a test (the bit is copied, inverted, into the zero flag), a clear, a set or an invert. The unit returns the modified operand and a write-enable that tells the surrounding datapath whether to store it back. The bit position comes from a count register or from an immediate field. A small decoder takes the second opcode byte of the bit group and works out the operation, the operand width and the offset source.

Five one-byte forms act on two flags that the unit holds itself. These forms invert the carry, clear or set the carry, and clear or set the direction flag. The unit also holds the zero, parity and sign flags that a test updates. Operand fetch, operand store and the rest of instruction decode belong to the caller.

Top module: `bitop_unit`

## Requirements
- R1: When `op_prefixed`=1, a code with bits 7:4 = 0001 is legal. In such a code, bits 2:1 pick the operation (00 test, 01 clear, 10 set, 11 invert), bit 3 picks the immediate (1) or count (0) offset, and bit 0 picks word (1) or byte (0). Every other prefixed code is illegal.
- R2: The bit index is `op_imm[2:0]` for bytes and `op_imm[3:0]` for words when bit 3 is set. Otherwise it is `op_count` modulo 8 for bytes and modulo 16 for words.
- R3: A test sets Z to the inverse of the selected bit. It sets S to the operand's top bit (bit 7 for bytes, bit 15 for words) and P to 1 when the low byte holds an even number of ones. It leaves `res_wr_en`=0 and returns the operand unchanged on `res_data`.
- R4: Clear, set and invert return the operand with only the selected bit forced to 0, forced to 1 or toggled, and raise `res_wr_en`. A byte operation leaves `res_data[15:8]` equal to the operand's upper byte.
- R5: Clear, set and invert on an operand leave all five flags unchanged.
- R6: When `op_prefixed`=0, the codes act on the flags as follows: F5h inverts the carry, F8h clears it, F9h sets it, FCh clears the direction flag and FDh sets it. These forms leave `res_wr_en`=0 and `res_data` equal to the operand.
- R7: An operand form, the invert-carry form and an illegal code give `res_valid` in the cycle after acceptance. The four carry/direction clear and set forms hold `op_busy` high for one cycle and give `res_valid` one cycle later.
- R8: An issue presented while `op_busy` is high is ignored: it changes no flag and produces no result.
- R9: An illegal code raises `res_illegal` with `res_wr_en`=0. It leaves all flags unchanged and returns the operand on `res_data`.
- R10: After reset, all five flags, `res_valid` and `op_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe |
| op_prefixed | input | 1 | 1: code is a bit-group second byte; 0: one-byte flag form |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 4 | Immediate bit index |
| op_count | input | 8 | Count register value |
| op_operand | input | 16 | Operand value |
| op_busy | output | 1 | A two-cycle flag form is in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Modified or passed-through operand |
| res_wr_en | output | 1 | Store `res_data` back |
| res_illegal | output | 1 | Code was not recognised |
| flag_cy | output | 1 | Carry flag |
| flag_dir | output | 1 | Direction flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Parity flag |
| flag_s | output | 1 | Sign flag |

## Verification
Operand operations, the carry invert and illegal codes are due one edge after the accepting edge. The bench drives each issue at a falling edge and samples everything at the next falling edge. For the four two-cycle flag forms, the bench first checks at that falling edge that `op_busy` is high and `res_valid` low, then samples the result one cycle later. The busy-ignore case keeps a second issue on the inputs through the busy cycle. It then checks the cycle after completion, when no stray result and no flag change may appear.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_NARROW_W = 8;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam logic [3:0]  GROUP_NIBBLE = 4'b0001;

  typedef enum logic [1:0] {
    BK_TEST  = 2'b00,
    BK_CLEAR = 2'b01,
    BK_SET   = 2'b10,
    BK_FLIP  = 2'b11
  } bitkind_e;

  typedef enum logic [2:0] {
    FK_NONE    = 3'd0,
    FK_FLIP_CY = 3'd1,
    FK_CLR_CY  = 3'd2,
    FK_SET_CY  = 3'd3,
    FK_CLR_DIR = 3'd4,
    FK_SET_DIR = 3'd5
  } flagkind_e;

  typedef struct packed {
    logic      legal;
    logic      on_operand;
    logic      use_imm;
    logic      word;
    logic      slow;
    bitkind_e  kind;
    flagkind_e fkind;
  } bitop_dec_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic       prefixed,
  input  logic [7:0] code,
  output bitop_dec_t dec
);
  always_comb begin
    dec            = '0;
    dec.kind       = BK_TEST;
    dec.fkind      = FK_NONE;
    if (prefixed) begin
      if (code[7:4] == GROUP_NIBBLE) begin
        dec.legal      = 1'b1;
        dec.on_operand = 1'b1;
        dec.use_imm    = code[3];
        dec.word       = code[0];
        dec.kind       = bitkind_e'(code[2:1]);
      end
    end else begin
      case (code)
        8'hF5: begin dec.legal = 1'b1; dec.fkind = FK_FLIP_CY; end
        8'hF8: begin dec.legal = 1'b1; dec.fkind = FK_CLR_CY;  dec.slow = 1'b1; end
        8'hF9: begin dec.legal = 1'b1; dec.fkind = FK_SET_CY;  dec.slow = 1'b1; end
        8'hFC: begin dec.legal = 1'b1; dec.fkind = FK_CLR_DIR; dec.slow = 1'b1; end
        8'hFD: begin dec.legal = 1'b1; dec.fkind = FK_SET_DIR; dec.slow = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NARROW_W = DEF_NARROW_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int IDX_W    = $clog2(DEF_DATA_W)
) (
  input  logic              word,
  input  logic              use_imm,
  input  bitkind_e          kind,
  input  logic [IDX_W-1:0]  imm,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val,
  output logic              sel_bit,
  output logic              top_bit,
  output logic              par_even
);
  localparam logic [IDX_W-1:0] NARROW_MASK = IDX_W'(NARROW_W - 1);

  function automatic logic [IDX_W-1:0] bit_index(input logic w, input logic from_imm,
                                                  input logic [IDX_W-1:0] iv,
                                                  input logic [CNT_W-1:0] cv);
    logic [IDX_W-1:0] raw;
    raw = from_imm ? iv : IDX_W'(cv % CNT_W'(DATA_W));
    return w ? raw : (raw & NARROW_MASK);
  endfunction

  function automatic logic [DATA_W-1:0] apply_kind(input bitkind_e k,
                                                    input logic [DATA_W-1:0] v,
                                                    input logic [IDX_W-1:0] ix);
    logic [DATA_W-1:0] sel;
    sel = {{(DATA_W-1){1'b0}}, 1'b1} << ix;
    case (k)
      BK_CLEAR: return v & ~sel;
      BK_SET:   return v | sel;
      BK_FLIP:  return v ^ sel;
      default:  return v;
    endcase
  endfunction

  logic [IDX_W-1:0] idx_w;

  always_comb begin
    idx_w    = bit_index(word, use_imm, imm, count);
    new_val  = apply_kind(kind, operand, idx_w);
    sel_bit  = operand[idx_w];
    top_bit  = word ? operand[DATA_W-1] : operand[NARROW_W-1];
    par_even = ~^operand[NARROW_W-1:0];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NARROW_W = DEF_NARROW_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_prefixed,
  input  logic [7:0]        op_code,
  input  logic [IDX_W-1:0]  op_imm,
  input  logic [CNT_W-1:0]  op_count,
  input  logic [DATA_W-1:0] op_operand,
  output logic              op_busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wr_en,
  output logic              res_illegal,
  output logic              flag_cy,
  output logic              flag_dir,
  output logic              flag_z,
  output logic              flag_p,
  output logic              flag_s
);
  bitop_dec_t        dec;
  logic [DATA_W-1:0] alu_val_w;
  logic              alu_bit_w, alu_top_w, alu_par_w;
  logic              accept_w, is_test_w, slow_done_w;
  logic [4:0]        flags_w;
  flagkind_e         pend_q;

  bitop_decode u_dec (.prefixed(op_prefixed), .code(op_code), .dec(dec));

  bitop_alu #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_alu (
    .word(dec.word), .use_imm(dec.use_imm), .kind(dec.kind), .imm(op_imm),
    .count(op_count), .operand(op_operand), .new_val(alu_val_w),
    .sel_bit(alu_bit_w), .top_bit(alu_top_w), .par_even(alu_par_w)
  );

  assign accept_w    = op_valid && !op_busy;
  assign is_test_w   = dec.on_operand && (dec.kind == BK_TEST);
  assign slow_done_w = op_busy;
  assign flags_w     = {flag_cy, flag_dir, flag_z, flag_p, flag_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_busy     <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_wr_en   <= 1'b0;
      res_illegal <= 1'b0;
      pend_q      <= FK_NONE;
      flag_cy     <= 1'b0;
      flag_dir    <= 1'b0;
      flag_z      <= 1'b0;
      flag_p      <= 1'b0;
      flag_s      <= 1'b0;
    end else begin
      res_valid   <= 1'b0;
      res_wr_en   <= 1'b0;
      res_illegal <= 1'b0;
      op_busy     <= 1'b0;
      if (slow_done_w) begin
        res_valid <= 1'b1;
        case (pend_q)
          FK_CLR_CY:  flag_cy  <= 1'b0;
          FK_SET_CY:  flag_cy  <= 1'b1;
          FK_CLR_DIR: flag_dir <= 1'b0;
          FK_SET_DIR: flag_dir <= 1'b1;
          default: ;
        endcase
      end else if (accept_w) begin
        res_data <= op_operand;
        if (!dec.legal) begin
          res_valid   <= 1'b1;
          res_illegal <= 1'b1;
        end else if (dec.on_operand) begin
          res_valid <= 1'b1;
          res_data  <= alu_val_w;
          res_wr_en <= !is_test_w;
          if (is_test_w) begin
            flag_z <= !alu_bit_w;
            flag_p <= alu_par_w;
            flag_s <= alu_top_w;
          end
        end else if (dec.slow) begin
          op_busy <= 1'b1;
          pend_q  <= dec.fkind;
        end else begin
          res_valid <= 1'b1;
          flag_cy   <= !flag_cy;
        end
      end
    end
  end

  assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> (!op_busy && res_valid));

  assert_fast_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !dec.slow) |=> (res_valid && !op_busy));

  assert_flags_kept_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_en |-> (flags_w == $past(flags_w)));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (!res_wr_en && res_valid && flags_w == $past(flags_w)));

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && dec.on_operand) |-> $onehot0(alu_val_w ^ op_operand));

  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && is_test_w) |=> (!res_wr_en && res_data == $past(op_operand)));

  assert_busy_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && op_valid) |=> ($stable(flag_z) && $stable(flag_p) && $stable(flag_s)));
endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_prefixed = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [3:0]  op_imm = 4'h0;
  logic [7:0]  op_count = 8'h00;
  logic [15:0] op_operand = 16'h0000;
  logic        op_busy, res_valid, res_wr_en, res_illegal;
  logic [15:0] res_data;
  logic        flag_cy, flag_dir, flag_z, flag_p, flag_s;

  int vectors = 0;
  int fails   = 0;
  logic m_cy = 0, m_dir = 0, m_z = 0, m_p = 0, m_s = 0;

  always #5 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_prefixed(op_prefixed),
    .op_code(op_code), .op_imm(op_imm), .op_count(op_count), .op_operand(op_operand),
    .op_busy(op_busy), .res_valid(res_valid), .res_data(res_data), .res_wr_en(res_wr_en),
    .res_illegal(res_illegal), .flag_cy(flag_cy), .flag_dir(flag_dir), .flag_z(flag_z),
    .flag_p(flag_p), .flag_s(flag_s)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " cy"},  {15'd0, flag_cy},  {15'd0, m_cy});
    chk({tag, " dir"}, {15'd0, flag_dir}, {15'd0, m_dir});
    chk({tag, " z"},   {15'd0, flag_z},   {15'd0, m_z});
    chk({tag, " p"},   {15'd0, flag_p},   {15'd0, m_p});
    chk({tag, " s"},   {15'd0, flag_s},   {15'd0, m_s});
  endtask

  // Issue one operation at a falling edge and check its result when due.
  task automatic run_op(input logic pre, input logic [7:0] code, input logic [3:0] imm,
                        input logic [7:0] cnt, input logic [15:0] opnd);
    logic legal, slow, word, wr;
    logic [1:0] kind;
    int idx, ones;
    logic [15:0] mask, exp;
    string tag;
    slow  = !pre && (code == 8'hF8 || code == 8'hF9 || code == 8'hFC || code == 8'hFD);
    legal = pre ? (code[7:4] == 4'h1) : (slow || code == 8'hF5);
    exp = opnd; wr = 1'b0; tag = "R9 illegal";
    if (legal && pre) begin
      word = code[0];
      kind = code[2:1];
      if (code[3]) idx = word ? int'(imm) : int'(imm) % 8;
      else         idx = word ? int'(cnt) % 16 : int'(cnt) % 8;
      mask = 16'h0001 << idx;
      case (kind)
        2'd1: exp = opnd & ~mask;
        2'd2: exp = opnd | mask;
        2'd3: exp = opnd ^ mask;
        default: exp = opnd;
      endcase
      wr = (kind != 2'd0);
      if (kind == 2'd0) begin
        tag = "R2/R3 test";
        m_z = ((opnd >> idx) & 16'h1) == 16'h0;
        m_s = word ? opnd[15] : opnd[7];
        ones = 0;
        for (int b = 0; b < 8; b++) ones += opnd[b];
        m_p = (ones % 2) == 0;
      end else tag = "R2/R4/R5 modify";
    end else if (legal) begin
      tag = "R6 flag form";
      case (code)
        8'hF5: m_cy = !m_cy;
        8'hF8: m_cy = 1'b0;
        8'hF9: m_cy = 1'b1;
        8'hFC: m_dir = 1'b0;
        default: m_dir = 1'b1;
      endcase
    end
    op_prefixed = pre; op_code = code; op_imm = imm; op_count = cnt; op_operand = opnd;
    op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    if (slow) begin
      chk("R7 busy during slow form", {15'd0, op_busy}, 16'd1);
      chk("R7 no early result", {15'd0, res_valid}, 16'd0);
      @(posedge clk); @(negedge clk);
    end
    chk({tag, " valid R7"}, {15'd0, res_valid}, 16'd1);
    chk({tag, " data"}, res_data, exp);
    chk({tag, " wr_en"}, {15'd0, res_wr_en}, {15'd0, wr});
    chk("R1/R9 illegal flag", {15'd0, res_illegal}, {15'd0, !legal});
    chk_flags(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk("R10 valid in reset", {15'd0, res_valid}, 16'd0);
    chk("R10 busy in reset", {15'd0, op_busy}, 16'd0);
    chk_flags("R10 flags in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", {15'd0, res_valid}, 16'd0);

    // R6: flag forms, including repeated carry invert
    run_op(1'b0, 8'hF5, 4'h0, 8'h00, 16'h1234);
    run_op(1'b0, 8'hF5, 4'h0, 8'h00, 16'h1234);
    run_op(1'b0, 8'hF9, 4'h0, 8'h00, 16'hBEEF);
    run_op(1'b0, 8'hFD, 4'h0, 8'h00, 16'h0F0F);
    run_op(1'b0, 8'hF8, 4'h0, 8'h00, 16'h0001);
    run_op(1'b0, 8'hFC, 4'h0, 8'h00, 16'h8000);
    run_op(1'b0, 8'hF9, 4'h0, 8'h00, 16'h0000);
    run_op(1'b0, 8'hFD, 4'h0, 8'h00, 16'h0000);

    // R1-style sweep of every legal second byte, every index, three operands (R2 R3 R4 R5)
    for (int oi = 0; oi < 3; oi++) begin
      for (int c = 16; c < 32; c++) begin
        for (int ix = 0; ix < 16; ix++) begin
          logic [15:0] v;
          v = (oi == 0) ? 16'hA5C3 : (oi == 1) ? 16'h0000 : 16'hFFFF;
          run_op(1'b1, 8'(c), 4'(ix), 8'(ix + 16 * (oi + 3)), v);
        end
      end
    end

    // R9: every unrecognised code in both classes
    for (int c = 0; c < 256; c++) begin
      if (c[7:4] != 4'h1) run_op(1'b1, 8'(c), 4'h5, 8'h07, 16'h5A3C);
      if (!(c == 8'hF5 || c == 8'hF8 || c == 8'hF9 || c == 8'hFC || c == 8'hFD))
        run_op(1'b0, 8'(c), 4'h2, 8'h03, 16'hC3A5);
    end

    // R8: an issue held through the busy cycle is ignored
    op_prefixed = 1'b0; op_code = 8'hFC; op_operand = 16'h7777; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 busy before ignore test", {15'd0, op_busy}, 16'd1);
    op_code = 8'hF5;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    m_dir = 1'b0;
    chk("R8 slow form completes", {15'd0, res_valid}, 16'd1);
    chk_flags("R8 after busy issue");
    @(posedge clk); @(negedge clk);
    chk("R8 no result for ignored issue", {15'd0, res_valid}, 16'd0);
    chk_flags("R8 flags untouched by ignored issue");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule